// File: doc/BRIEF.md
# Banked MMU TLB Register Interface

This block holds the support-function registers that a CPU core reaches with register-move instructions, and the software-managed TLB arrays behind them. The low two bits of a processor status word pick one of four register banks. Each bank has sixteen 32-bit registers. Banks 1 and 2 are the MMU banks. Each owns a TLB of 4 sets by 16 entries, and every entry holds a lo word and a hi word. Banks 0 and 3 are plain storage with no side effects.

In an MMU bank, three moves have side effects:
- Writing the hi register also fills the cause register.
- Writing the lo register commits a TLB entry at the position named by the select register. The entry takes its lo word from the written data and its hi word from the cause register. The commit raises a one-cycle page-invalidate strobe carrying the virtual page of the entry being replaced.
- Every read first reloads the hi and lo registers from the selected entry, and then returns the requested register.

A small output state machine sequences the responses. Its states are:
- `ST_IDLE`: nothing is presented.
- `ST_RD_RESP`: read data is presented with its acknowledge.
- `ST_FLUSH`: the invalidate strobe and its address are presented.

Its transitions are evaluated every cycle from any state:
- `GO_FLUSH`: a commit happened this cycle.
- `GO_RD`: an accepted read happened this cycle.
- `GO_IDLE`: neither happened.

Top module: `tlb_bank_ctrl`

## Requirements
- R1: After reset, every register of every bank and every TLB entry reads zero, and `rd_ack`, `rd_data`, `flush_valid` and `flush_vaddr` are all zero.
- R2: The active bank is `status_word[1:0]`, and bits 31:2 are ignored. In banks 0 and 3 a write to register r stores the data and a later read of r returns it. Writing register 6 there leaves register 7 unchanged, and writing register 5 there raises no flush.
- R3: In bank 1 or 2, writing register 6 (hi) also writes the same value into register 7 (cause) of that bank.
- R4: In bank 1 or 2, writing register 5 (lo) commits a TLB entry. The entry's lo word is the written data and its hi word is that bank's register 7. The entry is placed at set = register 4 bits 5:4 and entry = register 4 bits 3:0.
- R5: A commit raises `flush_valid` for exactly the next cycle. `flush_vaddr` then equals the replaced entry's old hi word with bits 12:0 cleared. No other write raises `flush_valid`.
- R6: A read in bank 1 or 2 first loads register 6 with the selected entry's hi word and register 5 with its lo word. It then returns the requested register, so reads of 5 and 6 return the entry words and the reloaded values persist.
- R7: A read request is answered in the next cycle: `rd_ack` is high for one cycle and `rd_data` carries the value. `rd_ack` is never high otherwise.
- R8: When `wr_valid` and `rd_valid` are both high in one cycle, the write is performed and the read is dropped, with no `rd_ack`.
- R9: Banks 1 and 2 own separate TLB arrays and separate registers. A commit or register write in one bank is not visible in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_word | input | 32 | Processor status word; bits 1:0 select the bank |
| wr_valid | input | 1 | One-cycle register write request |
| wr_reg | input | 4 | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | One-cycle register read request |
| rd_reg | input | 4 | Register number for the read |
| rd_ack | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data, zero when `rd_ack` is low |
| flush_valid | output | 1 | Page-invalidate strobe, one cycle after a commit |
| flush_vaddr | output | 32 | Page address of the replaced entry, bits 12:0 zero |

## Verification
A corrupted TLB word surfaces in two places. It shows in `rd_data` one cycle after any read of register 5 or 6 that selects that entry. It also shows in `flush_vaddr` on the cycle after the next commit to the same slot. The bench therefore sweeps all 64 slots of both MMU banks twice, so the second pass replaces non-zero entries. A wrong cause copy or a wrong bank decode shows as a wrong committed hi word, or as a stray or missing flush, within one cycle of the offending write.

// File: rtl/tlb_bank_pkg.sv
package tlb_bank_pkg;
    localparam int DATA_W     = 32;
    localparam int REG_AW     = 4;
    localparam int NUM_REGS   = 1 << REG_AW;
    localparam int BANK_AW    = 2;
    localparam int NUM_BANKS  = 1 << BANK_AW;
    localparam int SET_AW     = 2;
    localparam int WAY_AW     = 4;
    localparam int ENT_AW     = SET_AW + WAY_AW;
    localparam int NUM_ARR    = 2;
    localparam int ARR_AW     = $clog2(NUM_ARR);
    localparam int PAGE_SHIFT = 13;

    localparam logic [REG_AW-1:0]  SFR_SEL   = 4'd4;
    localparam logic [REG_AW-1:0]  SFR_LO    = 4'd5;
    localparam logic [REG_AW-1:0]  SFR_HI    = 4'd6;
    localparam logic [REG_AW-1:0]  SFR_CAUSE = 4'd7;
    localparam logic [BANK_AW-1:0] MMU_BANK_A = 2'd1;
    localparam logic [BANK_AW-1:0] MMU_BANK_B = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_FLUSH   = 2'd2
    } out_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_req_decode.sv
module tlb_req_decode
    import tlb_bank_pkg::*;
(
    input  logic [BANK_AW-1:0] bank_i,
    input  logic               wr_valid_i,
    input  logic [REG_AW-1:0]  wr_reg_i,
    input  logic               rd_valid_i,
    output logic               mmu_o,
    output logic [ARR_AW-1:0]  arr_o,
    output logic               do_write_o,
    output logic               do_read_o,
    output logic               hi_side_o,
    output logic               commit_o,
    output logic               reload_o
);
    always_comb begin
        mmu_o      = (bank_i == MMU_BANK_A) || (bank_i == MMU_BANK_B);
        arr_o      = (bank_i == MMU_BANK_B) ? ARR_AW'(1) : ARR_AW'(0);
        do_write_o = wr_valid_i;
        // a write in the same cycle wins; the read is dropped
        do_read_o  = rd_valid_i && !wr_valid_i;
        hi_side_o  = do_write_o && mmu_o && (wr_reg_i == SFR_HI);
        commit_o   = do_write_o && mmu_o && (wr_reg_i == SFR_LO);
        reload_o   = do_read_o && mmu_o;
    end
endmodule

// File: rtl/tlb_sfr_bank.sv
module tlb_sfr_bank
    import tlb_bank_pkg::*;
#(
    parameter int BANKS = NUM_BANKS,
    parameter int REGS  = NUM_REGS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BANK_AW-1:0] bank_i,
    input  logic               do_write_i,
    input  logic [REG_AW-1:0]  wr_reg_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               hi_side_i,
    input  logic               reload_i,
    input  tlb_entry_t         ent_i,
    input  logic [REG_AW-1:0]  rd_reg_i,
    output logic [DATA_W-1:0]  sel_o,
    output logic [DATA_W-1:0]  cause_o,
    output logic [DATA_W-1:0]  rd_word_o
);
    logic [DATA_W-1:0] regs_q [BANKS][REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BANKS; b++) begin
                for (int r = 0; r < REGS; r++) begin
                    regs_q[b][r] <= '0;
                end
            end
        end else begin
            if (do_write_i) begin
                regs_q[bank_i][wr_reg_i] <= wr_data_i;
                if (hi_side_i) begin
                    regs_q[bank_i][SFR_CAUSE] <= wr_data_i;
                end
            end
            if (reload_i) begin
                regs_q[bank_i][SFR_HI] <= ent_i.hi;
                regs_q[bank_i][SFR_LO] <= ent_i.lo;
            end
        end
    end

    always_comb begin
        sel_o     = regs_q[bank_i][SFR_SEL];
        cause_o   = regs_q[bank_i][SFR_CAUSE];
        rd_word_o = regs_q[bank_i][rd_reg_i];
        if (reload_i && (rd_reg_i == SFR_HI)) begin
            rd_word_o = ent_i.hi;
        end else if (reload_i && (rd_reg_i == SFR_LO)) begin
            rd_word_o = ent_i.lo;
        end
    end

    AST_CAUSE_COPY: assert property (@(posedge clk) disable iff (!rst_n) hi_side_i |=> (bank_i != $past(bank_i)) || (cause_o == $past(wr_data_i))); // R3
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_bank_pkg::*;
#(
    parameter int ARRS  = NUM_ARR,
    parameter int EAW   = ENT_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARR_AW-1:0] arr_i,
    input  logic [EAW-1:0]    addr_i,
    input  logic              commit_i,
    input  tlb_entry_t        wr_ent_i,
    output tlb_entry_t        rd_ent_o
);
    localparam int ENTRIES = 1 << EAW;

    tlb_entry_t mem_q [ARRS][ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ARRS; a++) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    mem_q[a][e] <= '0;
                end
            end
        end else if (commit_i) begin
            mem_q[arr_i][addr_i] <= wr_ent_i;
        end
    end

    assign rd_ent_o = mem_q[arr_i][addr_i];

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n) commit_i |=> (arr_i != $past(arr_i)) || (addr_i != $past(addr_i)) || (rd_ent_o == $past(wr_ent_i))); // R4
endmodule

// File: rtl/tlb_bank_ctrl.sv
module tlb_bank_ctrl
    import tlb_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] status_word,
    input  logic        wr_valid,
    input  logic [3:0]  wr_reg,
    input  logic [31:0] wr_data,
    input  logic        rd_valid,
    input  logic [3:0]  rd_reg,
    output logic        rd_ack,
    output logic [31:0] rd_data,
    output logic        flush_valid,
    output logic [31:0] flush_vaddr
);
    logic [BANK_AW-1:0] bank;
    logic               unused_status;
    logic               mmu, do_write, do_read, hi_side, commit, reload;
    logic [ARR_AW-1:0]  arr;
    logic [DATA_W-1:0]  sel_word, cause_word, rd_word;
    logic               unused_sel;
    tlb_entry_t         wr_ent, rd_ent;

    out_state_e         state_q, state_d;
    logic [DATA_W-1:0]  rd_q, flush_q;

    assign bank          = status_word[BANK_AW-1:0];
    assign unused_status = ^status_word[DATA_W-1:BANK_AW];
    assign unused_sel    = ^sel_word[DATA_W-1:ENT_AW];

    tlb_req_decode u_decode (
        .bank_i     (bank),
        .wr_valid_i (wr_valid),
        .wr_reg_i   (wr_reg),
        .rd_valid_i (rd_valid),
        .mmu_o      (mmu),
        .arr_o      (arr),
        .do_write_o (do_write),
        .do_read_o  (do_read),
        .hi_side_o  (hi_side),
        .commit_o   (commit),
        .reload_o   (reload)
    );

    tlb_sfr_bank u_sfr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_i     (bank),
        .do_write_i (do_write),
        .wr_reg_i   (wr_reg),
        .wr_data_i  (wr_data),
        .hi_side_i  (hi_side),
        .reload_i   (reload),
        .ent_i      (rd_ent),
        .rd_reg_i   (rd_reg),
        .sel_o      (sel_word),
        .cause_o    (cause_word),
        .rd_word_o  (rd_word)
    );

    assign wr_ent.hi = cause_word;
    assign wr_ent.lo = wr_data;

    tlb_entry_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_i    (arr),
        .addr_i   (sel_word[ENT_AW-1:0]),
        .commit_i (commit),
        .wr_ent_i (wr_ent),
        .rd_ent_o (rd_ent)
    );

    // next-state: GO_FLUSH, GO_RD, GO_IDLE from any state
    always_comb begin
        if (commit) begin
            state_d = ST_FLUSH;
        end else if (do_read) begin
            state_d = ST_RD_RESP;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
            flush_q <= '0;
        end else begin
            state_q <= state_d;
            if (do_read) begin
                rd_q <= rd_word;
            end
            if (commit) begin
                flush_q <= {rd_ent.hi[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
            end
        end
    end

    always_comb begin
        rd_ack      = 1'b0;
        rd_data     = '0;
        flush_valid = 1'b0;
        flush_vaddr = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_RESP: begin
                rd_ack  = 1'b1;
                rd_data = rd_q;
            end
            ST_FLUSH: begin
                flush_valid = 1'b1;
                flush_vaddr = flush_q;
            end
            default: ;
        endcase
    end

    AST_FLUSH_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) flush_valid |-> $past(wr_valid && (wr_reg == SFR_LO) && ((status_word[1:0] == MMU_BANK_A) || (status_word[1:0] == MMU_BANK_B)))); // R5
    AST_RD_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) rd_ack |-> $past(rd_valid && !wr_valid)); // R7
    AST_WRITE_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && rd_valid) |=> !rd_ack); // R8
    AST_MMU_READ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !wr_valid && mmu && (rd_reg == SFR_LO)) |=> rd_data == $past(rd_ent.lo)); // R6
endmodule

// File: tb/tlb_bank_ctrl_bench.sv
module tlb_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] status_word = '0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_reg = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [3:0]  rd_reg = '0;
    logic        rd_ack;
    logic [31:0] rd_data;
    logic        flush_valid;
    logic [31:0] flush_vaddr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] m_regs [4][16];
    logic [31:0] m_hi [2][64];
    logic [31:0] m_lo [2][64];

    always #10 clk = ~clk;

    tlb_bank_ctrl u_tlb_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .status_word(status_word),
        .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_reg(rd_reg),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .flush_valid(flush_valid), .flush_vaddr(flush_vaddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R7 actual=%0d expected<=150000", cyc);
            finish_run();
        end
    end

    function automatic bit is_mmu(input logic [1:0] b);
        return (b == 2'd1) || (b == 2'd2);
    endfunction

    task automatic set_bank(input logic [1:0] b, input logic [29:0] junk);
        status_word = {junk, b};
    endtask

    // write with model update; flush expectation per R4/R5/R2
    task automatic wr(input logic [3:0] r, input logic [31:0] d, input string tag);
        logic [1:0]  b;
        logic [5:0]  a;
        logic [31:0] old;
        bit          exp_fl;
        int          t;
        b = status_word[1:0];
        a = m_regs[b][4][5:0];
        t = int'(b) - 1;
        exp_fl = 1'b0;
        old = '0;
        @(negedge clk);
        wr_valid = 1'b1; wr_reg = r; wr_data = d;
        if (is_mmu(b) && r == 4'd5) begin
            exp_fl = 1'b1;
            old = m_hi[t][a];
            m_hi[t][a] = m_regs[b][7];
            m_lo[t][a] = d;
        end
        m_regs[b][r] = d;
        if (is_mmu(b) && r == 4'd6) m_regs[b][7] = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk({tag, " R5 flush_valid"}, 32'(flush_valid), 32'(exp_fl));
        if (exp_fl) chk({tag, " R5 flush_vaddr"}, flush_vaddr, old & 32'hFFFF_E000);
        chk({tag, " R7 no ack on write"}, 32'(rd_ack), 32'd0);
    endtask

    task automatic rd(input logic [3:0] r, input string tag);
        logic [1:0]  b;
        logic [5:0]  a;
        logic [31:0] exp;
        int          t;
        b = status_word[1:0];
        a = m_regs[b][4][5:0];
        t = int'(b) - 1;
        if (is_mmu(b)) begin
            m_regs[b][6] = m_hi[t][a];
            m_regs[b][5] = m_lo[t][a];
        end
        exp = m_regs[b][r];
        @(negedge clk);
        rd_valid = 1'b1; rd_reg = r;
        @(negedge clk);
        rd_valid = 1'b0;
        chk({tag, " R7 rd_ack"}, 32'(rd_ack), 32'd1);
        chk({tag, " rd_data"}, rd_data, exp);
        chk({tag, " R5 no flush on read"}, 32'(flush_valid), 32'd0);
        @(negedge clk);
        chk({tag, " R7 ack one cycle"}, 32'(rd_ack), 32'd0);
    endtask

    initial begin
        for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) m_regs[b][r] = '0;
        for (int t = 0; t < 2; t++) for (int e = 0; e < 64; e++) begin
            m_hi[t][e] = '0; m_lo[t][e] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 rd_ack in reset", 32'(rd_ack), 32'd0);
        chk("R1 flush_valid in reset", 32'(flush_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data after reset", rd_data, 32'd0);
        chk("R1 flush_vaddr after reset", flush_vaddr, 32'd0);

        // R1: reset contents
        for (int b = 0; b < 4; b++) begin
            set_bank(2'(b), 30'd0);
            for (int r = 0; r < 16; r++) rd(4'(r), "R1 reset reg");
        end

        // R2: plain banks, upper status bits ignored
        for (int b = 0; b < 4; b += 3) begin
            set_bank(2'(b), 30'h2AAA_5555 ^ 30'(b));
            for (int r = 0; r < 16; r++) wr(4'(r), 32'hC0DE_0000 | (b << 8) | r, "R2 plain write");
            for (int r = 0; r < 16; r++) rd(4'(r), "R2 plain read");
            wr(4'd6, 32'h1234_5678, "R2 hi no side effect");
            rd(4'd7, "R2 cause untouched");
            wr(4'd5, 32'h8765_4321, "R2 lo no commit");
            rd(4'd5, "R2 lo plain");
        end

        // R3/R4/R5/R6/R9: sweep every slot of both MMU banks, twice
        for (int p = 0; p < 2; p++) begin
            for (int b = 1; b <= 2; b++) begin
                set_bank(2'(b), 30'(p * 7 + b));
                for (int e = 0; e < 64; e++) begin
                    wr(4'd4, 32'hABC0_0000 | e, "R4 select");
                    wr(4'd6, 32'h1000_0000 * (p + 1) + (b << 20) + (e << 13) + 32'h5A + p, "R3 hi");
                    wr(4'd5, 32'h0F00_0000 + (p << 16) + (b << 8) + e, "R4 lo commit");
                end
                for (int e = 0; e < 64; e++) begin
                    wr(4'd4, 32'(e), "R6 select");
                    rd(4'd5, "R6 lo mirror");
                    rd(4'd6, "R6 hi mirror");
                    rd(4'd7, "R3 cause");
                end
            end
            // R9: other bank untouched by these writes
            set_bank(2'd1, 30'd0);
            wr(4'd6, 32'hDEAD_2000, "R9 hi bank1");
            set_bank(2'd2, 30'd0);
            rd(4'd7, "R9 bank2 cause");
            rd(4'd6, "R9 bank2 hi");
        end

        // R8: simultaneous write and read, write wins
        set_bank(2'd0, 30'd0);
        @(negedge clk);
        wr_valid = 1'b1; wr_reg = 4'd9; wr_data = 32'h5151_A0A0;
        rd_valid = 1'b1; rd_reg = 4'd9;
        m_regs[0][9] = 32'h5151_A0A0;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        chk("R8 read dropped", 32'(rd_ack), 32'd0);
        rd(4'd9, "R8 write landed");

        set_bank(2'd1, 30'd0);
        wr(4'd4, 32'd3, "R8 select");
        @(negedge clk);
        wr_valid = 1'b1; wr_reg = 4'd5; wr_data = 32'h7777_0003;
        rd_valid = 1'b1; rd_reg = 4'd5;
        m_hi[0][3] = m_regs[1][7];
        m_lo[0][3] = 32'h7777_0003;
        m_regs[1][5] = 32'h7777_0003;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        chk("R8 read dropped mmu", 32'(rd_ack), 32'd0);
        chk("R8 commit flush", 32'(flush_valid), 32'd1);
        rd(4'd5, "R8 commit landed");

        finish_run();
    end
endmodule